// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block holds one run bit for each peripheral in a design with up to 64 peripherals. It drives one clock-enable line per peripheral from that bit. The bits sit in two banks of 32. A peripheral's bit position within its bank, plus 32 for the upper bank, is its identifier, and that identifier is the same as its interrupt source number. Software never writes the run bits directly. For each bank it writes ones to a set register to start clocks, or ones to a clear register to stop them. It reads a per-bank status register to see which clocks are running.

A small word-addressed register bus is used. It has a 3-bit address, 32-bit write data, a write strobe and combinational read data. Address bit 2 selects the bank. Address bits 1:0 select the register: 0 is set, 1 is clear, 2 is status, and 3 is reserved. A stopped clock stops on the edge that takes the clear write, with no drain or handshake. Every run bit is cleared while reset is asserted. The reset input asserts asynchronously and is released in step with the clock through a two-stage synchronizer.

Top module: `periph_clk_gate`

## Requirements
- R1: While reset is held, and right after it, every `clk_en` bit is 0 and both status registers read 0.
- R2: A write to the set register (address bits 1:0 = 0) of bank b turns on `clk_en[32*b+i]` for every bit i written as 1. Bits written as 0 keep their state.
- R3: A write to the clear register (address bits 1:0 = 1) of bank b turns off `clk_en[32*b+i]` for every bit i written as 1. Bits written as 0 keep their state.
- R4: A set or clear write changes `clk_en` only on the rising clock edge that samples the write strobe, and not before that edge.
- R5: Reading the status register (address bits 1:0 = 2) of bank b returns `clk_en[32*b+31 : 32*b]`.
- R6: The set and clear registers always read as zero.
- R7: Writes to a status register have no effect on any `clk_en` bit.
- R8: A write to one bank leaves every `clk_en` bit of the other bank unchanged.
- R9: After `rst_n` rises, writes sampled on the first two rising clock edges are ignored. A write sampled on the third edge takes effect.
- R10: The reserved register (address bits 1:0 = 3) of each bank reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word address: bit 2 selects the bank, bits 1:0 select the register |
| bus_wdata | input | 32 | Write data, one bit per peripheral of the bank |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Combinational read data for the addressed register |
| clk_en | output | 64 | Clock enable per peripheral, indexed by identifier |

## Verification
The bench sweeps every one of the 64 identifiers through a set and then a clear, one at a time. A model in the bench predicts every output bit. This catches a wrong bank offset, a swapped bit order, or a write that overwrites instead of merging: each of those moves or loses bits in other positions. Each write is also checked just before its sampling edge, so a design that let the enables follow the bus combinationally would be seen changing early. Status and reserved writes are made with all-ones and all-zeros data while the run bits hold a mixed pattern, so a design that decoded those writes as set or clear would visibly change state. The window right after reset release is probed with a held write, which exposes a design that accepts writes before the synchronized reset has cleared.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // register select, taken from the low two word-address bits
  typedef enum logic [1:0] {
    REG_SET  = 2'd0,
    REG_CLR  = 2'd1,
    REG_STAT = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int REG_SEL_W = 2;

endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_AW   = 1
) (
  input  logic [BANK_AW+REG_SEL_W-1:0] addr,
  input  logic                         we,
  output logic [NUM_BANKS-1:0]         set_we,
  output logic [NUM_BANKS-1:0]         clr_we,
  output logic [BANK_AW-1:0]           bank_idx,
  output reg_sel_e                     rsel,
  output logic                         bank_ok
);

  always_comb begin
    bank_idx = addr[BANK_AW+REG_SEL_W-1:REG_SEL_W];
    rsel     = reg_sel_e'(addr[REG_SEL_W-1:0]);
    bank_ok  = ({1'b0, bank_idx} < (BANK_AW+1)'(NUM_BANKS));
    for (int b = 0; b < NUM_BANKS; b++) begin
      set_we[b] = we && bank_ok && (bank_idx == BANK_AW'(b)) && (rsel == REG_SET);
      clr_we[b] = we && bank_ok && (bank_idx == BANK_AW'(b)) && (rsel == REG_CLR);
    end
  end

  // R8: a bus write reaches at most one bank and one register kind
  always_comb begin
    one_strobe_chk: assert ($onehot0({set_we, clr_we}));
  end

endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q
);

  logic [BANK_W-1:0] set_v;
  logic [BANK_W-1:0] clr_v;
  logic [BANK_W-1:0] en_d;
  logic              upd;

  // next state: clear has priority over set on the same bit
  always_comb begin
    set_v = set_we ? wdata : '0;
    clr_v = clr_we ? wdata : '0;
    upd   = set_we | clr_we;
    en_d  = (en_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (upd) begin
      en_q <= en_d;
    end
  end

  // R2
  set_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

  // R3
  clr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(clr_v)) == '0));

  // R2
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (((en_q ^ $past(en_q)) & ~$past(wdata)) == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(en_q));

endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int BANK_AW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int ADDR_W    = BANK_AW + REG_SEL_W,
  parameter int NUM_PERIPH = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BANK_W-1:0]     bus_wdata,
  input  logic                  bus_we,
  output logic [BANK_W-1:0]     bus_rdata,
  output logic [NUM_PERIPH-1:0] clk_en
);

  logic                 rst_n_sync;
  logic [NUM_BANKS-1:0] set_we;
  logic [NUM_BANKS-1:0] clr_we;
  logic [BANK_AW-1:0]   bank_idx;
  reg_sel_e             rsel;
  logic                 bank_ok;
  logic [BANK_W-1:0]    bank_q [NUM_BANKS];

  pcg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pcg_decode #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_decode (
    .addr     (bus_addr),
    .we       (bus_we),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .bank_idx (bank_idx),
    .rsel     (rsel),
    .bank_ok  (bank_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pcg_bank #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .wdata  (bus_wdata),
      .en_q   (bank_q[b])
    );
    assign clk_en[b*BANK_W +: BANK_W] = bank_q[b];
  end

  // read path: only the status view returns data
  always_comb begin
    bus_rdata = '0;
    if (bank_ok && (rsel == REG_STAT)) begin
      bus_rdata = bank_q[bank_idx];
    end
  end

  // R7
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_we && rsel == REG_STAT) |=> $stable(clk_en));

  // R10
  rsvd_ro_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_we && rsel == REG_RSVD) |=> $stable(clk_en));

  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rsel == REG_SET || rsel == REG_CLR) |-> (bus_rdata == '0));

endmodule

// File: tb/periph_clk_gate_bench.sv
module periph_clk_gate_bench;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [63:0] clk_en;

  logic [63:0] model;
  int          n_run;
  int          n_fail;
  bit          finished;

  periph_clk_gate u_periph_clk_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus write; enables checked just before and just after the sampling edge
  task automatic wr(input int b, input int r, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_addr  = {b[0], r[1:0]};
    bus_wdata = d;
    bus_we    = 1'b1;
    #1 chk(clk_en, model, "R4 no change before edge");
    @(negedge clk);
    bus_we = 1'b0;
    if (r == 0) model[b*32 +: 32] = model[b*32 +: 32] | d;
    if (r == 1) model[b*32 +: 32] = model[b*32 +: 32] & ~d;
    chk(clk_en, model, tag);
  endtask

  task automatic rd(input int b, input int r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = {b[0], r[1:0]};
    #1 chk({32'h0, bus_rdata}, {32'h0, exp}, tag);
  endtask

  initial begin
    finished = 1'b0;
    #(CLK_P * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; model = '0;
    rst_n = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(clk_en, 64'h0, "R1 enables in reset");
    rd(0, 2, 32'h0, "R1 status bank0 in reset");
    rd(1, 2, 32'h0, "R1 status bank1 in reset");

    // R9: held write across reset release
    @(negedge clk);
    rst_n     = 1'b1;
    bus_addr  = 3'b000;
    bus_wdata = 32'h1;
    bus_we    = 1'b1;
    @(negedge clk);
    chk(clk_en, 64'h0, "R9 first edge ignored");
    @(negedge clk);
    chk(clk_en, 64'h0, "R9 second edge ignored");
    @(negedge clk);
    bus_we = 1'b0;
    chk(clk_en, 64'h1, "R9 third edge accepted");
    model = 64'h1;
    rd(0, 2, 32'h1, "R1 R5 status after release");
    wr(0, 1, 32'h1, "R3 restore");

    // R2 sweep: each identifier turned on alone
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 32; i++) begin
        wr(b, 0, 32'h1 << i, "R2 single set");
      end
      rd(b, 2, 32'hFFFF_FFFF, "R5 status all on");
      rd(b, 0, 32'h0, "R6 set reads zero");
      rd(b, 1, 32'h0, "R6 clear reads zero");
    end

    wr(0, 2, 32'h0, "R7 status write zeros ignored");
    wr(1, 3, 32'h0, "R10 reserved write zeros ignored");

    // R3 sweep: each identifier turned off alone, top down
    for (int b = 1; b >= 0; b--) begin
      for (int i = 31; i >= 0; i--) begin
        wr(b, 1, 32'h1 << i, "R3 single clear");
      end
      rd(b, 2, 32'h0, "R5 status all off");
    end

    // R8: bank isolation with mixed patterns
    wr(1, 0, 32'hA5A5_0F0F, "R8 set bank1");
    wr(0, 0, 32'h1234_5678, "R8 set bank0");
    wr(0, 1, 32'h0000_FFFF, "R8 clear bank0 low half");
    wr(0, 0, 32'h0000_0000, "R2 zero set no change");
    wr(1, 1, 32'h0000_0000, "R3 zero clear no change");
    rd(1, 2, 32'hA5A5_0F0F, "R8 bank1 untouched");
    rd(0, 2, 32'h1234_0000, "R8 bank0 merged");

    // R7 / R10 with mixed state
    wr(0, 2, 32'hFFFF_FFFF, "R7 status write ones ignored");
    wr(1, 2, 32'h0000_0000, "R7 status write bank1 ignored");
    wr(0, 3, 32'hFFFF_FFFF, "R10 reserved write ones ignored");
    rd(0, 3, 32'h0, "R10 reserved reads zero");
    rd(1, 3, 32'h0, "R10 reserved bank1 reads zero");
    rd(0, 2, 32'h1234_0000, "R7 bank0 status kept");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule